// File: doc/BRIEF.md
# Three-Phase LC Filter and RL Load Step Engine

This block advances the discrete-time model of a three-phase LC output filter and the RL load behind it by one slow time step per request. It holds nine state values: the three filter capacitor voltages, the three filter inductor currents and the three load currents. Each step request carries the three phase voltages produced by the bridge during the step just ended. The engine then computes the next filter state from the present filter state, those phase voltages and the present load currents. It also computes the next load currents from the present load currents and the present capacitor voltages.

A single multiply-accumulate unit is shared across all nine output rows. A full step takes 91 clock cycles. At a 50 MHz clock with a 10 µs step, 500 cycles are available. The matrix coefficients are loaded by an external agent through a plain write port while the engine is idle. The engine only applies the matrices and does not derive them. Step requests use a valid/ready handshake. `step_ready` is high only while the engine is idle. A request held on `step_valid` while `step_ready` is low is simply not taken and is never queued. The requester keeps `phase_v` stable until the accepting edge.

Top module: `lc_load_stepper`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, all nine state outputs read zero, `step_ready` is 1 and `done_o` is 0.
- R2: A step is accepted on a rising edge where `step_valid` and `step_ready` are both 1. `step_ready` is 0 from the next cycle until the cycle in which `done_o` is 1. Requests made while `step_ready` is 0 start no further update.
- R3: The filter state vector, ordered (capA, capB, capC, indA, indB, indC), is replaced by M·u. Here u = (capA, capB, capC, indA, indB, indC, vA, vB, vC, loadA, loadB, loadC). The coefficient of filter row r (0..5) and column c (0..11) sits at coefficient address r·12+c.
- R4: The load current vector (loadA, loadB, loadC) is replaced by N·w, where w = (loadA, loadB, loadC, capA, capB, capC). The coefficient of load row r (0..2) and column c (0..5) sits at address 72+r·6+c.
- R5: Every row uses only the state values held before the step. New results never feed into any row of the same step.
- R6: Coefficients and states are signed DW-bit values with FRAC fraction bits. Each row's exact sum of products is shifted right arithmetically by FRAC bits (rounding toward minus infinity) and saturated to the range −2^(DW−1) .. 2^(DW−1)−1.
- R7: The nine state outputs hold their values during an update and all change together. `done_o` is a one-cycle pulse that is high exactly 91 clock cycles after the accepting edge, and the new states are visible in that same cycle.
- R8: A coefficient write (`cfg_we` = 1) takes effect only on an edge where `step_ready` is 1. Writes presented during an update are discarded.
- R9: A coefficient write on the same edge that accepts a step is stored, and that step already uses the new value.
- R10: Asserting `rst` during an update abandons it: no `done_o` follows, and the states read zero.
- R11: Reset does not clear the coefficients. A step after reset uses the values written before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | Step request with phase voltages |
| step_ready | output | 1 | Engine idle, request will be taken |
| phase_v | input | 3·DW | Phase voltages A (bits DW−1:0), B, C |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | $clog2(90) | Coefficient address (see R3, R4) |
| cfg_data | input | DW | Coefficient value, signed fixed point |
| cap_v | output | 3·DW | Capacitor voltages A, B, C (A in low bits) |
| ind_i | output | 3·DW | Filter inductor currents A, B, C |
| load_i | output | 3·DW | Load currents A, B, C |
| done_o | output | 1 | One-cycle pulse when new states are visible |

## Verification
A coefficient write and the acceptance of a step can land on the same clock edge. The bench provokes this by raising `cfg_we` and `step_valid` at the same falling edge while the engine is idle. It judges the result against a reference model that applies the written coefficient before computing that step. The opposite case is also tested: writes and extra step requests presented mid-update must leave both the running step's result and the following step's result as if they never happened.

// File: rtl/lcl_pkg.sv
package lcl_pkg;
  localparam int N_PH      = 3;
  localparam int N_FILT    = 2 * N_PH;
  localparam int N_ROWS    = N_FILT + N_PH;
  localparam int FILT_COLS = N_FILT + 2 * N_PH;
  localparam int LOAD_COLS = 2 * N_PH;
  localparam int LOAD_BASE = N_FILT * FILT_COLS;
  localparam int N_COEF    = LOAD_BASE + N_PH * LOAD_COLS;
  localparam int N_MAC     = N_COEF;

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_COMMIT} step_phase_e;
endpackage

// File: rtl/lcl_coef_bank.sv
module lcl_coef_bank #(
  parameter int DW = 16,
  parameter int N  = 90,
  parameter int AW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [DW-1:0] wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic signed [DW-1:0] rd_data
);
  logic signed [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (wr_en && int'(wr_addr) < N) mem[wr_addr] <= wr_data;
  end

  assign rd_data = (int'(rd_addr) < N) ? mem[rd_addr] : '0;

  // stored word matches the accepted write one edge later
  p_coef_write_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_addr) < N) |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/lcl_mac.sv
module lcl_mac #(
  parameter int DW    = 16,
  parameter int FRAC  = 12,
  parameter int GUARD = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 first,
  input  logic signed [DW-1:0] coef,
  input  logic signed [DW-1:0] opnd,
  output logic signed [DW-1:0] result
);
  localparam int ACC_W = 2 * DW + GUARD;
  localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = {{(ACC_W-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [2*DW-1:0]  prod;
  logic signed [ACC_W-1:0] acc_q, sum, shifted;

  always_comb begin
    prod    = coef * opnd;
    sum     = (first ? '0 : acc_q) + ACC_W'(prod);
    shifted = sum >>> FRAC;
    if (shifted > MAXV)      result = MAXV[DW-1:0];
    else if (shifted < MINV) result = MINV[DW-1:0];
    else                     result = shifted[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= sum;
  end
endmodule

// File: rtl/lcl_step_seq.sv
module lcl_step_seq
  import lcl_pkg::*;
#(
  parameter int RW = $clog2(N_ROWS),
  parameter int CW = $clog2(FILT_COLS),
  parameter int IW = $clog2(N_COEF)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          mac_en,
  output logic          first,
  output logic          last,
  output logic          commit,
  output logic          is_load,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col,
  output logic [IW-1:0] coef_idx
);
  localparam int CNT_W = $clog2(N_MAC + 2);

  step_phase_e   phase_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;

  always_comb begin
    is_load  = int'(row_q) >= N_FILT;
    last     = is_load ? (int'(col_q) == LOAD_COLS - 1) : (int'(col_q) == FILT_COLS - 1);
    first    = (col_q == '0);
    mac_en   = (phase_q == PH_RUN);
    commit   = (phase_q == PH_COMMIT);
    busy     = (phase_q != PH_IDLE);
    row      = row_q;
    col      = col_q;
    coef_idx = is_load
      ? IW'(LOAD_BASE + (int'(row_q) - N_FILT) * LOAD_COLS + int'(col_q))
      : IW'(int'(row_q) * FILT_COLS + int'(col_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_RUN;
          row_q   <= '0;
          col_q   <= '0;
        end
        PH_RUN: if (last) begin
          col_q <= '0;
          if (int'(row_q) == N_ROWS - 1) phase_q <= PH_COMMIT;
          else                            row_q   <= row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // run-length watch counter for the bounded-latency check
  logic [CNT_W-1:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst || !busy) run_cnt <= '0;
    else              run_cnt <= run_cnt + 1'b1;
  end

  p_start_row0_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (phase_q == PH_RUN && row_q == '0 && col_q == '0));
  p_commit_ends_r7: assert property (@(posedge clk) disable iff (rst)
    commit |=> (phase_q == PH_IDLE));
  p_bounded_run_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (int'(run_cnt) <= N_MAC));
endmodule

// File: rtl/lc_load_stepper.sv
module lc_load_stepper
  import lcl_pkg::*;
#(
  parameter int DW    = 16,
  parameter int FRAC  = 12,
  parameter int GUARD = 8,
  parameter int AW    = $clog2(N_COEF)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_valid,
  output logic               step_ready,
  input  logic [N_PH*DW-1:0] phase_v,
  input  logic               cfg_we,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [DW-1:0]      cfg_data,
  output logic [N_PH*DW-1:0] cap_v,
  output logic [N_PH*DW-1:0] ind_i,
  output logic [N_PH*DW-1:0] load_i,
  output logic               done_o
);
  localparam int RW = $clog2(N_ROWS);
  localparam int CW = $clog2(FILT_COLS);

  logic signed [DW-1:0] st_q  [N_ROWS];
  logic signed [DW-1:0] nxt_q [N_ROWS];
  logic signed [DW-1:0] vin_q [N_PH];
  logic signed [DW-1:0] coef_w, opnd, mac_res;
  logic                 busy, mac_en, first, last, commit, is_load, start, done_q;
  logic [RW-1:0]        row_w;
  logic [CW-1:0]        col_w;
  logic [AW-1:0]        cidx;

  assign start      = step_valid && !busy;
  assign step_ready = !busy;
  assign done_o     = done_q;

  lcl_step_seq #(.RW(RW), .CW(CW), .IW(AW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .mac_en(mac_en),
    .first(first), .last(last), .commit(commit), .is_load(is_load),
    .row(row_w), .col(col_w), .coef_idx(cidx)
  );

  lcl_coef_bank #(.DW(DW), .N(N_COEF), .AW(AW)) u_coef (
    .clk(clk), .rst(rst), .wr_en(cfg_we && !busy), .wr_addr(cfg_addr),
    .wr_data(cfg_data), .rd_addr(cidx), .rd_data(coef_w)
  );

  lcl_mac #(.DW(DW), .FRAC(FRAC), .GUARD(GUARD)) u_mac (
    .clk(clk), .rst(rst), .en(mac_en), .first(first),
    .coef(coef_w), .opnd(opnd), .result(mac_res)
  );

  // operand select: filter u = (x, v, io); load w = (io, vo)
  always_comb begin
    int ci;
    ci   = int'(col_w);
    opnd = '0;
    if (!is_load) begin
      if (ci < N_FILT)             opnd = st_q[ci];
      else if (ci < N_FILT + N_PH) opnd = vin_q[ci - N_FILT];
      else                         opnd = st_q[ci - N_PH];
    end else begin
      if (ci < N_PH) opnd = st_q[N_FILT + ci];
      else           opnd = st_q[ci - N_PH];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ROWS; i++) begin
        st_q[i]  <= '0;
        nxt_q[i] <= '0;
      end
      for (int i = 0; i < N_PH; i++) vin_q[i] <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= commit;
      if (start)
        for (int i = 0; i < N_PH; i++) vin_q[i] <= phase_v[i*DW +: DW];
      if (mac_en && last) nxt_q[row_w] <= mac_res;
      if (commit)
        for (int i = 0; i < N_ROWS; i++) st_q[i] <= nxt_q[i];
    end
  end

  for (genvar g = 0; g < N_PH; g++) begin : g_out
    assign cap_v [g*DW +: DW] = st_q[g];
    assign ind_i [g*DW +: DW] = st_q[N_PH + g];
    assign load_i[g*DW +: DW] = st_q[N_FILT + g];
  end

  p_states_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(cap_v) && $stable(ind_i) && $stable(load_i)));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> !step_ready);
  p_done_ready_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> step_ready);
endmodule

// File: tb/lc_load_stepper_test.sv
module lc_load_stepper_test;
  localparam int DW = 16;
  localparam int FRAC = 12;
  localparam int NC = 90;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_valid = 1'b0;
  logic [3*DW-1:0] phase_v = '0;
  logic cfg_we = 1'b0;
  logic [6:0] cfg_addr = '0;
  logic [DW-1:0] cfg_data = '0;
  logic step_ready, done_o;
  logic [3*DW-1:0] cap_v, ind_i, load_i;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  longint cm [NC];
  longint ms [9];

  localparam int VECS [8][3] = '{
    '{1000, -2000, 1000}, '{5000, 0, -5000}, '{-12000, 6000, 6000},
    '{20000, -10000, -10000}, '{0, 0, 0}, '{-3000, -3000, 6000},
    '{15000, 15000, -30000}, '{7, -11, 4}
  };

  lc_load_stepper uut (
    .clk(clk), .rst(rst), .step_valid(step_valid), .step_ready(step_ready),
    .phase_v(phase_v), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .cap_v(cap_v), .ind_i(ind_i), .load_i(load_i), .done_o(done_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint outv(input int k);
    if (k < 3)      return longint'($signed(cap_v[k*DW +: DW]));
    else if (k < 6) return longint'($signed(ind_i[(k-3)*DW +: DW]));
    else            return longint'($signed(load_i[(k-6)*DW +: DW]));
  endfunction

  function automatic longint sat(input longint a);
    longint s;
    s = a >>> FRAC;
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  // reference: filter u = (x0..5, v, io), load w = (io, vo), all from step k
  task automatic model_step(input int va, input int vb, input int vc);
    longint u [12];
    longint w [6];
    longint nx [9];
    longint acc;
    for (int i = 0; i < 6; i++) u[i] = ms[i];
    u[6] = va; u[7] = vb; u[8] = vc;
    for (int i = 0; i < 3; i++) begin
      u[9+i] = ms[6+i];
      w[i]   = ms[6+i];
      w[3+i] = ms[i];
    end
    for (int r = 0; r < 6; r++) begin
      acc = 0;
      for (int c = 0; c < 12; c++) acc += cm[r*12+c] * u[c];
      nx[r] = sat(acc);
    end
    for (int r = 0; r < 3; r++) begin
      acc = 0;
      for (int c = 0; c < 6; c++) acc += cm[72+r*6+c] * w[c];
      nx[6+r] = sat(acc);
    end
    for (int i = 0; i < 9; i++) ms[i] = nx[i];
  endtask

  task automatic wr_coef(input int idx, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'(idx); cfg_data = DW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    cm[idx] = val;
  endtask

  task automatic set_v(input int va, input int vb, input int vc);
    phase_v = {DW'(vc), DW'(vb), DW'(va)};
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    chk(done_o == 1'b0, req, done_o, 0);
    while (!done_o && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(n == 91, {req, " latency"}, n, 91);
  endtask

  task automatic cmp_all(input string req);
    for (int k = 0; k < 9; k++) chk(outv(k) == ms[k], req, outv(k), ms[k]);
  endtask

  task automatic do_step(input int va, input int vb, input int vc, input string req);
    @(negedge clk);
    step_valid = 1'b1; set_v(va, vb, vc);
    @(negedge clk);
    step_valid = 1'b0;
    model_step(va, vb, vc);
    wait_done(req);
    cmp_all(req);
  endtask

  initial begin
    longint held [9];
    int dn;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int k = 0; k < 9; k++) chk(outv(k) == 0, "R1 state in reset", outv(k), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(step_ready == 1'b1, "R1 ready", step_ready, 1);
    chk(done_o == 1'b0, "R1 done", done_o, 0);
    for (int k = 0; k < 9; k++) ms[k] = 0;

    // load patterned coefficients (R3 / R4 address map)
    for (int i = 0; i < NC; i++) wr_coef(i, ((i * 37) % 29 - 14) * 64);
    cm[0] = 3600; wr_coef(0, 3600);
    cm[85] = 3000; wr_coef(85, 3000);

    // vector table walk: R3, R4, R5, R6
    for (int s = 0; s < 8; s++)
      do_step(VECS[s][0], VECS[s][1], VECS[s][2], "R3 R4 R5 R6 vector step");

    // R8: writes and extra requests during a running update
    @(negedge clk);
    step_valid = 1'b1; set_v(4000, -1000, 2500);
    @(negedge clk);
    step_valid = 1'b0;
    for (int k = 0; k < 9; k++) held[k] = outv(k);
    model_step(4000, -1000, 2500);
    repeat (10) @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'd0; cfg_data = 16'h7fff;
    step_valid = 1'b1; set_v(-5000, 9000, 100);
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (20) @(negedge clk);
    for (int k = 0; k < 9; k++) chk(outv(k) == held[k], "R7 hold mid-run", outv(k), held[k]);
    step_valid = 1'b0;
    while (!done_o) @(negedge clk);
    cmp_all("R8 busy write ignored");
    dn = 0;
    repeat (8) begin
      @(negedge clk);
      if (done_o) dn++;
    end
    chk(dn == 0, "R2 no queued step", dn, 0);
    chk(step_ready == 1'b1, "R2 ready after", step_ready, 1);
    do_step(-2500, 3000, 800, "R8 coef 0 kept");

    // R9: write on the accepting edge applies to that step
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'd6; cfg_data = 16'd4096;
    step_valid = 1'b1; set_v(1200, -700, 300);
    @(negedge clk);
    cfg_we = 1'b0; step_valid = 1'b0;
    cm[6] = 4096;
    model_step(1200, -700, 300);
    wait_done("R9 same-edge write");
    cmp_all("R9 same-edge write");

    // R6: saturation at both limits
    for (int i = 0; i < NC; i++) wr_coef(i, 0);
    wr_coef(6, 8192);
    wr_coef(19, 8192);
    do_step(30000, -30000, 0, "R6 saturation model");
    chk(outv(0) == 32767, "R6 positive clip", outv(0), 32767);
    chk(outv(1) == -32768, "R6 negative clip", outv(1), -32768);

    // R10: reset mid-update
    @(negedge clk);
    step_valid = 1'b1; set_v(100, 200, 300);
    @(negedge clk);
    step_valid = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 9; k++) chk(outv(k) == 0, "R10 cleared", outv(k), 0);
    chk(step_ready == 1'b1, "R10 ready", step_ready, 1);
    dn = 0;
    repeat (100) begin
      @(negedge clk);
      if (done_o) dn++;
    end
    chk(dn == 0, "R10 no done", dn, 0);
    for (int k = 0; k < 9; k++) ms[k] = 0;

    // R11: coefficients survive reset
    do_step(1000, 2000, 0, "R11 coef kept");
    chk(outv(0) == 2000, "R11 capA", outv(0), 2000);
    chk(outv(1) == 4000, "R11 capB", outv(1), 4000);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule